// File: doc/BRIEF.md
# Bridge MOSFET Short-Fault Monitor

This block supervises the six switches of a three-phase MOSFET bridge. It takes the gate commands and, for each switch, a digital flag from an external comparator. The flag says whether that switch's drain-source voltage is above the fault threshold. It then produces the gate drives actually sent to the bridge, an active-low general fault pin and a six-bit diagnostic register with one bit per switch.

A switch has just turned on when its driven gate goes from off to on. For that switch the comparator flag is not looked at until a programmable blanking interval has passed. The interval is a 4-bit count of 400 ns steps, and a count of zero counts as one step. If the flag is still high once the interval is over, the switch is recorded as shorted. A shorted high-side switch means its phase is shorted to ground. A shorted low-side switch means its phase is shorted to supply. A shorted winding therefore shows up as a high-side and a low-side bit captured together.

With the latch enable set, captured bits are held, the fault pin stays low and every gate drive is forced off until a diagnostic clear. With the latch enable clear, the register follows live detection and the drives are left alone. A run bit of zero forces every drive off.

The interface carries no data stream, so all pins are plain control and status levels: there is no valid/ready handshake and no back-pressure.

Top module: `bridge_short_monitor`

## Requirements
- R1: After reset, `gate_out` is all zero, `diag_q` is all zero and `fault_n` is 1.
- R2: With `run_en` = 1 and no latched shutdown, `gate_out` equals `gate_cmd` in the same cycle. With `run_en` = 0, `gate_out` is all zero whatever the other inputs, and no fault can be captured.
- R3: Let L = `blank_sel` × `CLK_PER_TICK` clock cycles, where `CLK_PER_TICK` cycles make 400 ns. A switch's flag is ignored for the first L rising clock edges on which its drive is on. If the drive and the flag are both high after the L-th such edge, the diagnostic bit is set by the next edge.
- R4: A `blank_sel` value of 0 gives the same blanking as a value of 1 (L = `CLK_PER_TICK`).
- R5: A drive that goes off, even for one cycle, restarts that switch's blanking from zero on its next turn-on. A flag that falls before the interval ends produces no fault.
- R6: Bit i of `diag_q`, `gate_cmd`, `gate_out` and `vds_hi` belongs to the same switch. Bits 0, 1 and 2 are the high-side switches of phases A, B and C, and a fault there means a phase short to ground. Bits 3, 4 and 5 are the low-side switches of phases A, B and C, and a fault there means a phase short to supply.
- R7: `fault_n` is 0 exactly when at least one `diag_q` bit is 1.
- R8: With `latch_en` = 1, a captured bit stays set and all of `gate_out` stays zero until `diag_clr` is pulsed.
- R9: With `latch_en` = 0, `diag_q` shows the faults detected in the previous cycle, and a fault never disables the drives.
- R10: `diag_clr` wins over a fault detected in the same cycle: after the clear edge `diag_q` is zero.
- R11: High-side and low-side faults detected in the same cycle are captured together in `diag_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_cmd | input | 6 | Requested gate state per switch (bits 0-2 high side A/B/C, bits 3-5 low side A/B/C) |
| vds_hi | input | 6 | Comparator flag per switch, 1 = drain-source voltage above threshold |
| blank_sel | input | 4 | Blanking length in 400 ns steps; 0 acts as 1 |
| latch_en | input | 1 | 1 = hold faults and shut the bridge off |
| run_en | input | 1 | 0 = force all gate drives off |
| diag_clr | input | 1 | Single-cycle strobe clearing the diagnostic register |
| gate_out | output | 6 | Gate drives sent to the bridge |
| fault_n | output | 1 | General fault pin, low while any diagnostic bit is set |
| diag_q | output | 6 | Per-switch short diagnostic register |

## Verification
The bound checker confirms on every cycle that:
- a low run bit keeps every drive off;
- a latched fault keeps the bridge off and holds its bit until a clear;
- a clear always leaves the register empty;
- no diagnostic bit rises unless that switch was driven with its flag high in the previous cycle.

Only the bench scenarios can show the exact length of the blanking window for several field values, including zero. The same holds for:
- the restart of blanking after a brief turn-off;
- a flag that drops inside the window and is therefore ignored;
- the capture of a high-side and a low-side fault together;
- the mapping of each switch to its register bit.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
  localparam int N_DEV   = 6;  // three phases, high and low side
  localparam int N_PHASE = 3;
  localparam int BT_W    = 4;  // width of blank-time field
  localparam int LS_BASE = N_PHASE; // first low-side bit index
endpackage

// File: rtl/bsm_limit_calc.sv
module bsm_limit_calc #(
  parameter int CLK_PER_TICK = 100,
  parameter int BT_W         = 4,
  parameter int CNT_W        = 11
) (
  input  logic [BT_W-1:0]  blank_sel,
  output logic [CNT_W-1:0] limit
);
  logic [BT_W-1:0] n_eff;

  // zero is promoted to a single step
  always_comb begin
    n_eff = (blank_sel == '0) ? BT_W'(1) : blank_sel;
    limit = CNT_W'(n_eff) * CNT_W'(CLK_PER_TICK);
  end
endmodule

// File: rtl/bsm_blank_timer.sv
module bsm_blank_timer #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             on,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  // held at zero while off, so every turn-on starts a fresh window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!on)
      cnt_q <= '0;
    else if (cnt_q < limit)
      cnt_q <= cnt_q + 1'b1;
  end

  assign expired = on && (cnt_q >= limit);
endmodule

// File: rtl/bsm_diag_reg.sv
module bsm_diag_reg #(
  parameter int N_DEV = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DEV-1:0] fault_now,
  input  logic             latch_en,
  input  logic             diag_clr,
  output logic [N_DEV-1:0] diag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      diag_q <= '0;
    else if (diag_clr)
      diag_q <= '0;                 // clear beats same-cycle capture
    else if (latch_en)
      diag_q <= diag_q | fault_now; // sticky
    else
      diag_q <= fault_now;          // live view
  end
endmodule

// File: rtl/bridge_short_monitor.sv
module bridge_short_monitor
  import bsm_pkg::*;
#(
  parameter int CLK_PER_TICK = 100 // clock cycles per 400 ns step
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DEV-1:0] gate_cmd,
  input  logic [N_DEV-1:0] vds_hi,
  input  logic [BT_W-1:0]  blank_sel,
  input  logic             latch_en,
  input  logic             run_en,
  input  logic             diag_clr,
  output logic [N_DEV-1:0] gate_out,
  output logic             fault_n,
  output logic [N_DEV-1:0] diag_q
);
  localparam int MAX_LIMIT = ((1 << BT_W) - 1) * CLK_PER_TICK;
  localparam int CNT_W     = $clog2(MAX_LIMIT + 1);

  logic [CNT_W-1:0] limit;
  logic [N_DEV-1:0] expired;
  logic [N_DEV-1:0] fault_now;
  logic             shut;

  bsm_limit_calc #(
    .CLK_PER_TICK(CLK_PER_TICK),
    .BT_W        (BT_W),
    .CNT_W       (CNT_W)
  ) u_limit (
    .blank_sel(blank_sel),
    .limit    (limit)
  );

  // latched shutdown and run gating
  assign shut     = latch_en & (|diag_q);
  assign gate_out = gate_cmd & {N_DEV{run_en & ~shut}};

  for (genvar i = 0; i < N_DEV; i++) begin : g_dev
    bsm_blank_timer #(.CNT_W(CNT_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .on     (gate_out[i]),
      .limit  (limit),
      .expired(expired[i])
    );
  end

  assign fault_now = expired & vds_hi;

  bsm_diag_reg #(.N_DEV(N_DEV)) u_diag (
    .clk      (clk),
    .rst_n    (rst_n),
    .fault_now(fault_now),
    .latch_en (latch_en),
    .diag_clr (diag_clr),
    .diag_q   (diag_q)
  );

  assign fault_n = ~(|diag_q);
endmodule

// File: rtl/bsm_checker.sv
module bsm_checker #(
  parameter int N_DEV = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             latch_en,
  input logic             diag_clr,
  input logic [N_DEV-1:0] gate_out,
  input logic [N_DEV-1:0] vds_hi,
  input logic [N_DEV-1:0] diag_q
);
  // R2
  run_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> gate_out == '0);

  // R8
  latch_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_en && (|diag_q)) |-> gate_out == '0);

  // R10
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    diag_clr |=> diag_q == '0);

  for (genvar i = 0; i < N_DEV; i++) begin : g_bit
    // R8
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_en && diag_q[i] && !diag_clr) |=> diag_q[i]);

    // R3
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(diag_q[i]) |-> $past(gate_out[i] && vds_hi[i]));
  end
endmodule

bind bridge_short_monitor bsm_checker #(.N_DEV(N_DEV)) u_bsm_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .run_en  (run_en),
  .latch_en(latch_en),
  .diag_clr(diag_clr),
  .gate_out(gate_out),
  .vds_hi  (vds_hi),
  .diag_q  (diag_q)
);

// File: tb/bridge_short_monitor_test.sv
`timescale 1ns/1ps
module bridge_short_monitor_test;
  localparam int TICK = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] gate_cmd = '0;
  logic [5:0] vds_hi = '0;
  logic [3:0] blank_sel = 4'd3;
  logic       latch_en = 1'b0;
  logic       run_en = 1'b1;
  logic       diag_clr = 1'b0;
  logic [5:0] gate_out;
  logic       fault_n;
  logic [5:0] diag_q;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bridge_short_monitor #(.CLK_PER_TICK(TICK)) uut (
    .clk(clk), .rst_n(rst_n), .gate_cmd(gate_cmd), .vds_hi(vds_hi),
    .blank_sel(blank_sel), .latch_en(latch_en), .run_en(run_en),
    .diag_clr(diag_clr), .gate_out(gate_out), .fault_n(fault_n),
    .diag_q(diag_q)
  );

  function automatic int blank_cycles(input int n);
    return ((n == 0) ? 1 : n) * TICK;
  endfunction

  task automatic adv(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic settle();
    gate_cmd = '0; vds_hi = '0; diag_clr = 1'b1;
    adv(1);
    diag_clr = 1'b0; latch_en = 1'b0; run_en = 1'b1;
    adv(1);
  endtask

  task automatic t_reset();
    chk("R1 gate_out", gate_out, '0);
    chk("R1 diag_q", diag_q, '0);
    chk("R1 fault_n", {5'b0, fault_n}, 6'd1);
  endtask

  task automatic t_run();
    run_en = 1'b1;
    gate_cmd = 6'b100_001; adv(1); chk("R2 pass A", gate_out, 6'b100_001);
    gate_cmd = 6'b010_100; adv(1); chk("R2 pass B", gate_out, 6'b010_100);
    run_en = 1'b0; vds_hi = 6'b111_111;
    adv(blank_cycles(int'(blank_sel)) + 3);
    chk("R2 run off drive", gate_out, '0);
    chk("R2 run off no fault", diag_q, '0);
    settle();
  endtask

  // flag high from turn-on; fault must appear exactly one edge after L
  task automatic t_blank(input int n, input int idx, input string tag);
    int len;
    len = blank_cycles(n);
    blank_sel = 4'(n);
    vds_hi[idx] = 1'b1; gate_cmd[idx] = 1'b1;
    adv(len);
    chk({tag, " still blank"}, diag_q, '0);
    adv(1);
    chk({tag, " captured R6"}, diag_q, 6'(1 << idx));
    chk({tag, " R7 fault_n low"}, {5'b0, fault_n}, 6'd0);
    chk({tag, " R9 drive kept"}, gate_out, 6'(1 << idx));
    vds_hi[idx] = 1'b0;
    adv(1);
    chk({tag, " R9 live clears"}, diag_q, '0);
    chk({tag, " R7 fault_n high"}, {5'b0, fault_n}, 6'd1);
    settle();
  endtask

  task automatic t_restart();
    int len;
    blank_sel = 4'd3; len = blank_cycles(3);
    vds_hi[5] = 1'b1; gate_cmd[5] = 1'b1;
    adv(len - 2);
    gate_cmd[5] = 1'b0; adv(1); gate_cmd[5] = 1'b1;
    adv(len);
    chk("R5 restart no early fault", diag_q, '0);
    adv(1);
    chk("R5 restart fault after full window", diag_q, 6'b100_000);
    settle();
    vds_hi[1] = 1'b1; gate_cmd[1] = 1'b1;
    adv(len - 1);
    vds_hi[1] = 1'b0;
    adv(4);
    chk("R5 flag dropped in window", diag_q, '0);
    settle();
  endtask

  task automatic t_latch();
    int len;
    blank_sel = 4'd2; len = blank_cycles(2);
    latch_en = 1'b1;
    gate_cmd = 6'b001_010; vds_hi = 6'b001_000;
    adv(len + 1);
    chk("R8 low-side A captured R6", diag_q, 6'b001_000);
    chk("R8 bridge off", gate_out, '0);
    vds_hi = '0;
    adv(5);
    chk("R8 held", diag_q, 6'b001_000);
    chk("R8 still off", gate_out, '0);
    chk("R8 R7 pin low", {5'b0, fault_n}, 6'd0);
    diag_clr = 1'b1; adv(1); diag_clr = 1'b0;
    chk("R8 cleared", diag_q, '0);
    chk("R8 drives back", gate_out, 6'b001_010);
    settle();
  endtask

  task automatic t_winding();
    int len;
    blank_sel = 4'd1; len = blank_cycles(1);
    latch_en = 1'b1;
    gate_cmd = 6'b010_001; vds_hi = 6'b010_001;
    adv(len + 1);
    chk("R11 both sides captured", diag_q, 6'b010_001);
    settle();
  endtask

  task automatic t_clear_prio();
    int len;
    blank_sel = 4'd2; len = blank_cycles(2);
    latch_en = 1'b1;
    gate_cmd[2] = 1'b1; vds_hi[2] = 1'b1;
    adv(len);
    diag_clr = 1'b1; adv(1); diag_clr = 1'b0;
    chk("R10 clear beats detection", diag_q, '0);
    chk("R10 drive still on", gate_out, 6'b000_100);
    adv(1);
    chk("R10 capture after clear", diag_q, 6'b000_100);
    settle();
  endtask

  initial begin
    adv(3);
    rst_n = 1'b1;
    adv(1);
    t_reset();
    t_run();
    t_blank(3, 0, "R3 n3 highA");
    t_blank(9, 4, "R3 n9 lowB");
    t_blank(15, 2, "R3 n15 highC");
    t_blank(0, 3, "R4 n0 lowA");
    t_blank(1, 1, "R4 n1 highB");
    t_restart();
    t_latch();
    t_winding();
    t_clear_prio();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule